// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block links two agents, each on its own clock, through a pair of first-in first-out queues of 18-bit words: one queue carries traffic from port A to port B, the other from port B to port A, and both run at the same time. Each port has a single request strobe and a direction select. In a given cycle the port either pushes the word on its input bus into the outbound queue, or pulls the oldest word of the inbound queue into its output register. Each port also has a drive-enable output that stands in for the control of a shared bus.

A per-port skip control lets a word bypass the queues. A skip write parks the word in the port's input register only. A skip read on the other port copies that parked word into its output register. Each queue reports full and almost-full to its writer and empty and almost-empty to its reader. The two almost thresholds of each queue are kept in a small register bank that is clocked by port A and reached through a select, a write strobe and a 3-bit address. Queue pointers cross clock domains as Gray codes.

Top module: `bififo_pair`

## Requirements
- R1: Words pushed at port A (en=1, wr=1, skip=0) are delivered at port B in the order they were pushed. Words pushed at port B reach port A the same way. The two queues are independent, and data stays intact while pushes and pulls overlap in time.
- R2: A pull (en=1, wr=0, skip=0) on a non-empty queue loads the oldest word into the port's output register at that rising edge. While en=0, the output register keeps its value.
- R3: A push while the writer's full flag is high is discarded. After DEPTH words are accepted, further pushes store nothing, and the reader gets exactly the first DEPTH words.
- R4: A pull while the reader's empty flag is high leaves the output register unchanged and moves no pointer, so the next word pushed is the next word pulled.
- R5: After reset, both queues are empty, with empty=1, almost-empty=1, full=0 and almost-full=0. Both outputs and both drive enables are 0, and all four thresholds read back 8.
- R6: Full is high in the writer's domain exactly when DEPTH words are stored. Empty is high in the reader's domain when no word is stored, once pointer transfer has settled.
- R7: Almost-empty is high when occupancy is less than or equal to that queue's empty threshold. Almost-full is high when free space is less than or equal to its full threshold.
- R8: The threshold map is: address 0 = A-to-B empty threshold, 1 = A-to-B full threshold, 2 = B-to-A empty threshold, 3 = B-to-A full threshold. A write with select=1 and write strobe=1 updates the addressed threshold on the port A edge. A read with select=1 and write strobe=0 returns it on cfg_rdata after that edge. Writes to addresses 4 to 7 change nothing, and reads of those addresses return 0.
- R9: A skip write (en=1, wr=1, skip=1) captures the word in the port's input register and leaves the outbound queue's occupancy unchanged.
- R10: A skip read (en=1, wr=0, skip=1) loads the output register with the other port's input register, which holds the most recent word written at that port, queued or skipped. It does not pop the inbound queue.
- R11: Each drive output equals that port's output enable as sampled at the previous rising edge. The output enable has no effect on the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| a_en | input | 1 | Port A transfer request |
| a_wr | input | 1 | Port A direction: 1 push, 0 pull |
| a_byp | input | 1 | Port A skip control for the queue |
| a_oe | input | 1 | Port A output enable |
| a_din | input | 18 | Port A write data |
| a_dout | output | 18 | Port A output register |
| a_drive | output | 1 | Port A registered bus drive enable |
| b_en | input | 1 | Port B transfer request |
| b_wr | input | 1 | Port B direction: 1 push, 0 pull |
| b_byp | input | 1 | Port B skip control for the queue |
| b_oe | input | 1 | Port B output enable |
| b_din | input | 18 | Port B write data |
| b_dout | output | 18 | Port B output register |
| b_drive | output | 1 | Port B registered bus drive enable |
| cfg_cs | input | 1 | Threshold bank select (port A clock) |
| cfg_we | input | 1 | Threshold bank write strobe |
| cfg_addr | input | 3 | Threshold address |
| cfg_wdata | input | log2(DEPTH)+1 | Threshold write value |
| cfg_rdata | output | log2(DEPTH)+1 | Threshold read value |
| ab_full | output | 1 | A-to-B queue full (clk_a) |
| ab_afull | output | 1 | A-to-B queue almost full (clk_a) |
| ab_empty | output | 1 | A-to-B queue empty (clk_b) |
| ab_aempty | output | 1 | A-to-B queue almost empty (clk_b) |
| ba_full | output | 1 | B-to-A queue full (clk_b) |
| ba_afull | output | 1 | B-to-A queue almost full (clk_b) |
| ba_empty | output | 1 | B-to-A queue empty (clk_a) |
| ba_aempty | output | 1 | B-to-A queue almost empty (clk_a) |

## Verification
The two operations that can land in the same cycle are a push into a queue on one clock and a pull from that same queue on the other clock, at the point where the queue is almost drained. The bench provokes this by running a writer and a reader for each direction at once, with random gaps. The reader pulls as soon as its empty flag drops, so the Gray pointer crossing is exercised at occupancy zero and one. Each pulled word is compared with a model queue that the writer fills only when it sees full low. A word lost, repeated or reordered in the crossing shows up as a data mismatch.

// File: rtl/bififo_pkg.sv
`timescale 1ns/1ps
package bififo_pkg;

    localparam int WORD_W     = 18;
    localparam int GRAY_MAX   = 16;
    localparam int DEF_OFFSET = 8;
    localparam int CFG_AW     = 3;

    typedef enum logic [CFG_AW-1:0] {
        SEL_AB_LOW  = 3'd0,
        SEL_AB_HIGH = 3'd1,
        SEL_BA_LOW  = 3'd2,
        SEL_BA_HIGH = 3'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic              byp;
        logic [WORD_W-1:0] data;
    } port_cmd_t;

    function automatic logic [GRAY_MAX-1:0] bin_to_gray(input logic [GRAY_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX-1:0] gray_to_bin(input logic [GRAY_MAX-1:0] g);
        logic [GRAY_MAX-1:0] b;
        b[GRAY_MAX-1] = g[GRAY_MAX-1];
        for (int i = GRAY_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/bififo_sync2.sv
`timescale 1ns/1ps
module bififo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bififo_queue.sv
`timescale 1ns/1ps
module bififo_queue
    import bififo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PW-1:0]     high_off,
    output logic              full,
    output logic              afull,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              pop,
    input  logic [PW-1:0]     low_off,
    output logic [WORD_W-1:0] rdata,
    output logic              empty,
    output logic              aempty
);
    logic [WORD_W-1:0] mem [DEPTH];

    logic [PW-1:0] wbin, wgray, rgray_at_w, rbin_at_w, wcount, wbin_nx;
    logic [PW-1:0] rbin, rgray, wgray_at_r, wbin_at_r, rcount, rbin_nx;
    logic          do_push, do_pop;

    // write domain
    assign rbin_at_w = PW'(gray_to_bin(GRAY_MAX'(rgray_at_w)));
    assign wcount    = wbin - rbin_at_w;
    assign full      = (wcount == PW'(DEPTH));
    assign afull     = ((PW'(DEPTH) - wcount) <= high_off);
    assign do_push   = push && !full;
    assign wbin_nx   = wbin + 1'b1;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (do_push) begin
            wbin  <= wbin_nx;
            wgray <= PW'(bin_to_gray(GRAY_MAX'(wbin_nx)));
        end
    end

    always_ff @(posedge wclk) begin
        if (do_push) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    // read domain
    assign wbin_at_r = PW'(gray_to_bin(GRAY_MAX'(wgray_at_r)));
    assign rcount    = wbin_at_r - rbin;
    assign empty     = (rcount == '0);
    assign aempty    = (rcount <= low_off);
    assign do_pop    = pop && !empty;
    assign rbin_nx   = rbin + 1'b1;
    assign rdata     = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (do_pop) begin
            rbin  <= rbin_nx;
            rgray <= PW'(bin_to_gray(GRAY_MAX'(rbin_nx)));
        end
    end

    bififo_sync2 #(.W(PW)) u_sync_r2w (
        .clk (wclk),
        .rst (wrst),
        .d   (rgray),
        .q   (rgray_at_w)
    );

    bififo_sync2 #(.W(PW)) u_sync_w2r (
        .clk (rclk),
        .rst (rrst),
        .d   (wgray),
        .q   (wgray_at_r)
    );
endmodule

// File: rtl/bififo_port.sv
`timescale 1ns/1ps
module bififo_port
    import bififo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_cmd_t         cmd,
    input  logic              oe,
    input  logic              in_empty,
    input  logic [WORD_W-1:0] in_data,
    input  logic [WORD_W-1:0] peer_hold,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              pop,
    output logic [WORD_W-1:0] hold,
    output logic [WORD_W-1:0] dout,
    output logic              drive
);
    logic is_write, is_read;

    assign is_write  = cmd.en && cmd.wr;
    assign is_read   = cmd.en && !cmd.wr;
    assign push      = is_write && !cmd.byp;
    assign pop       = is_read && !cmd.byp;
    assign push_data = cmd.data;

    // input register: last word presented on a write, queued or skipped
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (is_write) begin
            hold <= cmd.data;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (is_read) begin
            if (cmd.byp) begin
                dout <= peer_hold;
            end else if (!in_empty) begin
                dout <= in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive <= 1'b0;
        end else begin
            drive <= oe;
        end
    end
endmodule

// File: rtl/bififo_cfg.sv
`timescale 1ns/1ps
module bififo_cfg
    import bififo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [PW-1:0]     wdata,
    output logic [PW-1:0]     rdata,
    output logic [1:0][PW-1:0] low_off,
    output logic [1:0][PW-1:0] high_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < 2; d++) begin
                low_off[d]  <= PW'(DEF_OFFSET);
                high_off[d] <= PW'(DEF_OFFSET);
            end
        end else if (cs && we) begin
            for (int d = 0; d < 2; d++) begin
                if (addr == CFG_AW'(2 * d))     low_off[d]  <= wdata;
                if (addr == CFG_AW'(2 * d + 1)) high_off[d] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cs && !we) begin
            case (cfg_sel_e'(addr))
                SEL_AB_LOW:  rdata <= low_off[0];
                SEL_AB_HIGH: rdata <= high_off[0];
                SEL_BA_LOW:  rdata <= low_off[1];
                SEL_BA_HIGH: rdata <= high_off[1];
                default:     rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/bififo_pair.sv
`timescale 1ns/1ps
module bififo_pair
    import bififo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                      clk_a,
    input  logic                      clk_b,
    input  logic                      rst,
    input  logic                      a_en,
    input  logic                      a_wr,
    input  logic                      a_byp,
    input  logic                      a_oe,
    input  logic [WORD_W-1:0]         a_din,
    output logic [WORD_W-1:0]         a_dout,
    output logic                      a_drive,
    input  logic                      b_en,
    input  logic                      b_wr,
    input  logic                      b_byp,
    input  logic                      b_oe,
    input  logic [WORD_W-1:0]         b_din,
    output logic [WORD_W-1:0]         b_dout,
    output logic                      b_drive,
    input  logic                      cfg_cs,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [$clog2(DEPTH):0]    cfg_wdata,
    output logic [$clog2(DEPTH):0]    cfg_rdata,
    output logic                      ab_full,
    output logic                      ab_afull,
    output logic                      ab_empty,
    output logic                      ab_aempty,
    output logic                      ba_full,
    output logic                      ba_afull,
    output logic                      ba_empty,
    output logic                      ba_aempty
);
    localparam int PW = $clog2(DEPTH) + 1;

    // index 0 = port A, 1 = port B; queue d carries port d -> port 1-d
    logic [1:0]             clk_v, oe_v;
    port_cmd_t [1:0]        cmd;
    logic [1:0]             push_v, pop_v;
    logic [1:0][WORD_W-1:0] push_data, hold, dout_v, q_rdata;
    logic [1:0]             drive_v;
    logic [1:0]             q_full, q_afull, q_empty, q_aempty;
    logic [1:0][PW-1:0]     low_off, high_off;

    assign clk_v  = {clk_b, clk_a};
    assign oe_v   = {b_oe, a_oe};
    assign cmd[0] = '{en: a_en, wr: a_wr, byp: a_byp, data: a_din};
    assign cmd[1] = '{en: b_en, wr: b_wr, byp: b_byp, data: b_din};

    for (genvar p = 0; p < 2; p++) begin : g_port
        localparam int IN_Q = 1 - p;
        bififo_port u_port (
            .clk       (clk_v[p]),
            .rst       (rst),
            .cmd       (cmd[p]),
            .oe        (oe_v[p]),
            .in_empty  (q_empty[IN_Q]),
            .in_data   (q_rdata[IN_Q]),
            .peer_hold (hold[IN_Q]),
            .push      (push_v[p]),
            .push_data (push_data[p]),
            .pop       (pop_v[p]),
            .hold      (hold[p]),
            .dout      (dout_v[p]),
            .drive     (drive_v[p])
        );
    end

    for (genvar d = 0; d < 2; d++) begin : g_queue
        localparam int RD_PORT = 1 - d;
        bififo_queue #(.DEPTH(DEPTH)) u_queue (
            .wclk     (clk_v[d]),
            .wrst     (rst),
            .push     (push_v[d]),
            .wdata    (push_data[d]),
            .high_off (high_off[d]),
            .full     (q_full[d]),
            .afull    (q_afull[d]),
            .rclk     (clk_v[RD_PORT]),
            .rrst     (rst),
            .pop      (pop_v[RD_PORT]),
            .low_off  (low_off[d]),
            .rdata    (q_rdata[d]),
            .empty    (q_empty[d]),
            .aempty   (q_aempty[d])
        );
    end

    bififo_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk      (clk_a),
        .rst      (rst),
        .cs       (cfg_cs),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .low_off  (low_off),
        .high_off (high_off)
    );

    assign a_dout    = dout_v[0];
    assign b_dout    = dout_v[1];
    assign a_drive   = drive_v[0];
    assign b_drive   = drive_v[1];
    assign ab_full   = q_full[0];
    assign ab_afull  = q_afull[0];
    assign ab_empty  = q_empty[0];
    assign ab_aempty = q_aempty[0];
    assign ba_full   = q_full[1];
    assign ba_afull  = q_afull[1];
    assign ba_empty  = q_empty[1];
    assign ba_aempty = q_aempty[1];
endmodule

// File: rtl/bififo_pair_chk.sv
`timescale 1ns/1ps
module bififo_pair_chk
    import bififo_pkg::*;
(
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst,
    input logic              a_en,
    input logic              a_wr,
    input logic              a_byp,
    input logic              a_oe,
    input logic [WORD_W-1:0] a_dout,
    input logic              a_drive,
    input logic              b_en,
    input logic              b_wr,
    input logic              b_byp,
    input logic              b_oe,
    input logic [WORD_W-1:0] b_dout,
    input logic              b_drive,
    input logic              ab_full,
    input logic              ab_afull,
    input logic              ab_empty,
    input logic              ab_aempty,
    input logic              ba_full,
    input logic              ba_afull,
    input logic              ba_empty,
    input logic              ba_aempty
);
    p_ab_full_afull_r7: assert property (@(posedge clk_a) disable iff (rst)
        ab_full |-> ab_afull);
    p_ba_full_afull_r7: assert property (@(posedge clk_b) disable iff (rst)
        ba_full |-> ba_afull);
    p_ab_empty_aempty_r7: assert property (@(posedge clk_b) disable iff (rst)
        ab_empty |-> ab_aempty);
    p_ba_empty_aempty_r7: assert property (@(posedge clk_a) disable iff (rst)
        ba_empty |-> ba_aempty);

    p_a_drive_on_r11: assert property (@(posedge clk_a) disable iff (rst)
        a_oe |=> a_drive);
    p_a_drive_off_r11: assert property (@(posedge clk_a) disable iff (rst)
        !a_oe |=> !a_drive);
    p_b_drive_on_r11: assert property (@(posedge clk_b) disable iff (rst)
        b_oe |=> b_drive);
    p_b_drive_off_r11: assert property (@(posedge clk_b) disable iff (rst)
        !b_oe |=> !b_drive);

    p_a_idle_hold_r2: assert property (@(posedge clk_a) disable iff (rst)
        !a_en |=> $stable(a_dout));
    p_b_idle_hold_r2: assert property (@(posedge clk_b) disable iff (rst)
        !b_en |=> $stable(b_dout));

    p_a_empty_pull_r4: assert property (@(posedge clk_a) disable iff (rst)
        (ba_empty && a_en && !a_wr && !a_byp) |=> $stable(a_dout));
    p_b_empty_pull_r4: assert property (@(posedge clk_b) disable iff (rst)
        (ab_empty && b_en && !b_wr && !b_byp) |=> $stable(b_dout));
endmodule

bind bififo_pair bififo_pair_chk u_chk (
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .rst       (rst),
    .a_en      (a_en),
    .a_wr      (a_wr),
    .a_byp     (a_byp),
    .a_oe      (a_oe),
    .a_dout    (a_dout),
    .a_drive   (a_drive),
    .b_en      (b_en),
    .b_wr      (b_wr),
    .b_byp     (b_byp),
    .b_oe      (b_oe),
    .b_dout    (b_dout),
    .b_drive   (b_drive),
    .ab_full   (ab_full),
    .ab_afull  (ab_afull),
    .ab_empty  (ab_empty),
    .ab_aempty (ab_aempty),
    .ba_full   (ba_full),
    .ba_afull  (ba_afull),
    .ba_empty  (ba_empty),
    .ba_aempty (ba_aempty)
);

// File: tb/bififo_pair_bench.sv
`timescale 1ns/1ps
module bififo_pair_bench;
    import bififo_pkg::*;

    localparam int DEPTH = 256;
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam int NRAND = 60;

    logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
    logic a_en = 0, a_wr = 0, a_byp = 0, a_oe = 0;
    logic b_en = 0, b_wr = 0, b_byp = 0, b_oe = 0;
    logic [WORD_W-1:0] a_din = '0, b_din = '0;
    logic [WORD_W-1:0] a_dout, b_dout;
    logic a_drive, b_drive;
    logic cfg_cs = 0, cfg_we = 0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic [PW-1:0] cfg_rdata;
    logic ab_full, ab_afull, ab_empty, ab_aempty;
    logic ba_full, ba_afull, ba_empty, ba_aempty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [WORD_W-1:0] model_q [$];

    always #2   clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    bififo_pair #(.DEPTH(DEPTH)) u_bififo_pair (.*);

    function automatic logic [WORD_W-1:0] fill_word(input int i);
        return WORD_W'(i * 37 + 11);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // port tasks: called at a negedge of the port clock, return one period later
    task automatic a_op(input logic wr, input logic byp, input logic [WORD_W-1:0] d);
        a_en = 1; a_wr = wr; a_byp = byp; a_din = d;
        @(negedge clk_a);
        a_en = 0; a_wr = 0; a_byp = 0;
    endtask

    task automatic b_op(input logic wr, input logic byp, input logic [WORD_W-1:0] d);
        b_en = 1; b_wr = wr; b_byp = byp; b_din = d;
        @(negedge clk_b);
        b_en = 0; b_wr = 0; b_byp = 0;
    endtask

    task automatic cfg_write(input logic [CFG_AW-1:0] ad, input logic [PW-1:0] v);
        cfg_cs = 1; cfg_we = 1; cfg_addr = ad; cfg_wdata = v;
        @(negedge clk_a);
        cfg_cs = 0; cfg_we = 0;
    endtask

    task automatic cfg_read(input logic [CFG_AW-1:0] ad, output logic [PW-1:0] v);
        cfg_cs = 1; cfg_we = 0; cfg_addr = ad;
        @(negedge clk_a);
        cfg_cs = 0;
        v = cfg_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] rv;
        logic [WORD_W-1:0] last;
        int seed_init;
        seed_init = $urandom(32'd4217);

        repeat (5) @(negedge clk_b);
        @(negedge clk_a);
        rst = 0;
        @(negedge clk_a);

        // R5 reset state
        check("R5", "ab_empty", ab_empty, 1);
        check("R5", "ab_aempty", ab_aempty, 1);
        check("R5", "ab_full", ab_full, 0);
        check("R5", "ab_afull", ab_afull, 0);
        check("R5", "ba_empty", ba_empty, 1);
        check("R5", "ba_full", ba_full, 0);
        check("R5", "a_dout", a_dout, 0);
        check("R5", "b_dout", b_dout, 0);
        check("R5", "a_drive", a_drive, 0);
        check("R5", "b_drive", b_drive, 0);
        for (int k = 0; k < 4; k++) begin
            cfg_read(CFG_AW'(k), rv);
            check("R5", "default threshold", rv, DEF_OFFSET);
        end

        // R8 threshold bank
        cfg_write(3'd0, 9'd3);
        cfg_write(3'd1, 9'd5);
        cfg_write(3'd6, 9'd7);
        cfg_read(3'd0, rv); check("R8", "addr0", rv, 3);
        cfg_read(3'd1, rv); check("R8", "addr1", rv, 5);
        cfg_read(3'd6, rv); check("R8", "addr6 reads zero", rv, 0);
        cfg_read(3'd2, rv); check("R8", "addr2 untouched", rv, DEF_OFFSET);
        cfg_read(3'd3, rv); check("R8", "addr3 untouched", rv, DEF_OFFSET);

        // R1 R2 R7: three words then a fourth, low threshold 3
        a_op(1, 0, 18'h00111);
        a_op(1, 0, 18'h00222);
        a_op(1, 0, 18'h00333);
        @(negedge clk_b);
        repeat (10) @(negedge clk_b);
        check("R6", "ab_empty with 3 words", ab_empty, 0);
        check("R7", "ab_aempty at 3", ab_aempty, 1);
        @(negedge clk_a);
        a_op(1, 0, 18'h3ABCD);
        @(negedge clk_b);
        repeat (10) @(negedge clk_b);
        check("R7", "ab_aempty at 4", ab_aempty, 0);
        b_op(0, 0, '0); check("R1", "word 0", b_dout, 18'h00111);
        b_op(0, 0, '0); check("R2", "word 1", b_dout, 18'h00222);
        b_op(0, 0, '0); check("R1", "word 2", b_dout, 18'h00333);
        b_op(0, 0, '0); check("R1", "word 3", b_dout, 18'h3ABCD);
        repeat (3) @(negedge clk_b);
        check("R2", "idle hold", b_dout, 18'h3ABCD);
        check("R6", "ab_empty after drain", ab_empty, 1);

        // R4 pull on empty
        b_op(0, 0, '0);
        check("R4", "empty pull keeps dout", b_dout, 18'h3ABCD);
        @(negedge clk_a);
        a_op(1, 0, 18'h00155);
        @(negedge clk_b);
        repeat (10) @(negedge clk_b);
        b_op(0, 0, '0);
        check("R4", "next word after empty pull", b_dout, 18'h00155);

        // R3 R6 R7: fill past DEPTH, high threshold 5
        @(negedge clk_a);
        repeat (10) @(negedge clk_a);
        for (int i = 0; i < DEPTH + 3; i++) begin
            a_op(1, 0, fill_word(i));
            if (i + 1 == DEPTH - 6) check("R7", "ab_afull at free 6", ab_afull, 0);
            if (i + 1 == DEPTH - 5) check("R7", "ab_afull at free 5", ab_afull, 1);
            if (i + 1 == DEPTH - 1) check("R6", "ab_full at DEPTH-1", ab_full, 0);
            if (i + 1 == DEPTH)     check("R6", "ab_full at DEPTH", ab_full, 1);
        end
        check("R3", "ab_full after extra pushes", ab_full, 1);
        @(negedge clk_b);
        repeat (10) @(negedge clk_b);
        check("R6", "ab_empty when full", ab_empty, 0);
        for (int j = 0; j < DEPTH; j++) begin
            b_op(0, 0, '0);
            check("R3", "stored word", b_dout, fill_word(j));
        end
        check("R3", "empty after DEPTH pulls", ab_empty, 1);
        b_op(0, 0, '0);
        check("R3", "no extra word stored", b_dout, fill_word(DEPTH - 1));

        // R9 R10 skip path
        @(negedge clk_a);
        a_op(1, 0, 18'h00F0F);
        a_op(1, 1, 18'h0A0A0);
        @(negedge clk_b);
        repeat (10) @(negedge clk_b);
        check("R9", "skip write not queued", ab_aempty & !ab_empty, 1);
        b_op(0, 1, '0);
        check("R10", "skip read B", b_dout, 18'h0A0A0);
        b_op(0, 0, '0);
        check("R10", "queue not popped by skip", b_dout, 18'h00F0F);
        check("R9", "ab_empty after", ab_empty, 1);
        b_op(1, 1, 18'h13579);
        @(negedge clk_a);
        repeat (10) @(negedge clk_a);
        check("R9", "ba_empty after skip write", ba_empty, 1);
        a_op(0, 1, '0);
        check("R10", "skip read A", a_dout, 18'h13579);

        // R11 drive enable
        a_oe = 1;
        check("R11", "a_drive before edge", a_drive, 0);
        @(negedge clk_a);
        check("R11", "a_drive after edge", a_drive, 1);
        check("R11", "oe leaves a_dout", a_dout, 18'h13579);
        a_oe = 0;
        @(negedge clk_a);
        check("R11", "a_drive released", a_drive, 0);
        @(negedge clk_b);
        b_oe = 1;
        @(negedge clk_b);
        check("R11", "b_drive after edge", b_drive, 1);
        b_oe = 0;
        @(negedge clk_b);
        check("R11", "b_drive released", b_drive, 0);

        // R1 concurrent A->B: push and pull overlap near empty
        model_q.delete();
        @(negedge clk_a);
        fork
            begin
                int sent = 0;
                while (sent < NRAND) begin
                    if ($urandom % 3 == 0) @(negedge clk_a);
                    else if (!ab_full) begin
                        logic [WORD_W-1:0] d;
                        d = WORD_W'($urandom);
                        model_q.push_back(d);
                        a_op(1, 0, d);
                        sent++;
                    end else @(negedge clk_a);
                end
            end
            begin
                int got = 0;
                @(negedge clk_b);
                while (got < NRAND) begin
                    if (!ab_empty && model_q.size() > 0) begin
                        last = model_q.pop_front();
                        b_op(0, 0, '0);
                        check("R1", "concurrent A->B word", b_dout, last);
                        got++;
                    end else @(negedge clk_b);
                end
            end
        join

        // R1 concurrent B->A
        model_q.delete();
        @(negedge clk_b);
        fork
            begin
                int sent = 0;
                while (sent < NRAND) begin
                    if ($urandom % 4 == 0) @(negedge clk_b);
                    else if (!ba_full) begin
                        logic [WORD_W-1:0] d;
                        d = WORD_W'($urandom);
                        model_q.push_back(d);
                        b_op(1, 0, d);
                        sent++;
                    end else @(negedge clk_b);
                end
            end
            begin
                int got = 0;
                @(negedge clk_a);
                while (got < NRAND) begin
                    if (!ba_empty && model_q.size() > 0) begin
                        last = model_q.pop_front();
                        a_op(0, 0, '0);
                        check("R1", "concurrent B->A word", a_dout, last);
                        got++;
                    end else @(negedge clk_a);
                end
            end
        join
        @(negedge clk_a);
        check("R6", "ba_empty at end", ba_empty, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule